// File: doc/BRIEF.md
# Indirect Clock-Control Register Port

This block gives a host two byte-wide locations through which it reaches a bank of clock-control registers. One location is a pointer byte. It holds a six-bit register index and a write-enable flag. The other location is a data byte, which is a window onto the register that the pointer selects. To read a register, the host loads the pointer with write-enable clear and then reads the window. A write takes three steps: load the pointer with write-enable set, write the window, then load the pointer again with write-enable clear to close the write.

Every register is also driven out continuously as a sideband vector, so the clock logic nearby uses the programmed values directly. All registers reset to zero. Indices at or above the implemented count read as zero and ignore writes. Stored data is limited to the configured field width.

Top module: `clkreg_port`

## Requirements
- R1: After reset the pointer byte reads 0x00 and every register, on the sideband vector and through the window, is zero.
- R2: A host write to the pointer byte (sel_i=0) stores bits [7:1] of the written value, and bit 0 always reads back as 0. The value is readable from the next cycle.
- R3: Pointer bits [7:2] are the register index and pointer bit 1 is the write-enable flag.
- R4: A window write (sel_i=1, wr_i=1) while write-enable is 1 and the index is below NUM_REGS stores the written byte, masked to DATA_W bits, into the indexed register. The new value is visible from the next cycle.
- R5: A window write while write-enable is 0 is ignored, and no register changes.
- R6: With sel_i=1, rdata_o shows the indexed register in the same cycle. Indices at or above NUM_REGS (default 48) read as zero, and writes to them change nothing.
- R7: After the pointer is rewritten with write-enable clear and the same index, later window writes leave the register at its committed value.
- R8: In the cycle of a window write, rdata_o still shows the register's previous value. The new value appears one cycle later.
- R9: Register i is driven on regs_o[i*DATA_W +: DATA_W] at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Location select: 0 = pointer byte, 1 = data window |
| wr_i | input | 1 | Host write strobe for the selected location |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Read data of the selected location (combinational) |
| regs_o | output | NUM_REGS*DATA_W | All registers, register i at slice i |

## Verification
A window write and a window read of the same register fall in the same cycle, because the read path is combinational and the write path is registered. The bench drives a window write to a register that already holds a known value. It samples rdata_o before the clock edge, where the old value is expected, and samples it again after the edge, where the new value is expected. The reference model runs alongside on every clock, so any early or late commit shows up as a mismatch.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;
  localparam int unsigned IDX_W  = 6;
  localparam int unsigned BYTE_W = 8;

  // pointer byte layout: index [7:2], write enable [1], reserved [0]
  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             we;
    logic             rsvd;
  } ptr_byte_t;

  function automatic ptr_byte_t to_ptr(input logic [BYTE_W-1:0] b);
    ptr_byte_t p;
    p.idx  = b[BYTE_W-1:2];
    p.we   = b[1];
    p.rsvd = 1'b0;
    return p;
  endfunction
endpackage

// File: rtl/clkreg_ptr.sv
module clkreg_ptr
  import clkreg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output ptr_byte_t         ptr_o
);
  ptr_byte_t ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= to_ptr(wdata_i);
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/clkreg_bank.sv
module clkreg_bank
  import clkreg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 48,
  parameter int unsigned DATA_W   = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [BYTE_W-1:0]          wdata_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic [DATA_W-1:0] wval;
  assign wval = wdata_i[DATA_W-1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] r_q;
    logic              hit;
    assign hit = wr_en_i && (idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  r_q <= '0;
      else if (hit) r_q <= wval;
    end
    assign regs_o[g*DATA_W +: DATA_W] = r_q;
  end
endmodule

// File: rtl/clkreg_rdmux.sv
module clkreg_rdmux
  import clkreg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 48,
  parameter int unsigned DATA_W   = 8
) (
  input  logic                       sel_i,
  input  ptr_byte_t                  ptr_i,
  input  logic [NUM_REGS*DATA_W-1:0] regs_i,
  output logic [BYTE_W-1:0]          rdata_o
);
  logic [BYTE_W-1:0] win;

  always_comb begin
    win = '0;  // unimplemented indices read zero
    for (int i = 0; i < NUM_REGS; i++) begin
      if (ptr_i.idx == IDX_W'(i)) win = BYTE_W'(regs_i[i*DATA_W +: DATA_W]);
    end
  end

  assign rdata_o = sel_i ? win : ptr_i;
endmodule

// File: rtl/clkreg_port.sv
module clkreg_port
  import clkreg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 48,
  parameter int unsigned DATA_W   = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sel_i,
  input  logic                       wr_i,
  input  logic [7:0]                 wdata_i,
  output logic [7:0]                 rdata_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  ptr_byte_t ptr_q;
  logic      ptr_load;
  logic      commit;

  assign ptr_load = wr_i && !sel_i;
  assign commit   = wr_i && sel_i && ptr_q.we;

  clkreg_ptr u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (ptr_load),
    .wdata_i (wdata_i),
    .ptr_o   (ptr_q)
  );

  clkreg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (commit),
    .idx_i   (ptr_q.idx),
    .wdata_i (wdata_i),
    .regs_o  (regs_o)
  );

  clkreg_rdmux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd (
    .sel_i   (sel_i),
    .ptr_i   (ptr_q),
    .regs_i  (regs_o),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/clkreg_port_chk.sv
module clkreg_port_chk #(
  parameter int unsigned NUM_REGS = 48,
  parameter int unsigned DATA_W   = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       sel_i,
  input logic                       wr_i,
  input logic [7:0]                 wdata_i,
  input logic [7:0]                 rdata_o,
  input logic [NUM_REGS*DATA_W-1:0] regs_o,
  input logic [7:0]                 ptr_q
);
  logic              prev_commit;
  logic [5:0]        prev_idx;
  logic [DATA_W-1:0] prev_data;
  logic [DATA_W-1:0] cur_slice;
  logic              impl;

  assign impl = int'(ptr_q[7:2]) < NUM_REGS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_commit <= 1'b0;
      prev_idx    <= '0;
      prev_data   <= '0;
    end else begin
      prev_commit <= wr_i && sel_i && ptr_q[1] && impl;
      prev_idx    <= ptr_q[7:2];
      prev_data   <= wdata_i[DATA_W-1:0];
    end
  end

  always_comb begin
    cur_slice = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (prev_idx == 6'(i)) cur_slice = regs_o[i*DATA_W +: DATA_W];
  end

  AST_PTR_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sel_i) |=> (ptr_q == {$past(wdata_i[7:1]), 1'b0}));  // R2

  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && !sel_i) |=> $stable(ptr_q));  // R7

  AST_BANK_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prev_commit |-> (cur_slice == prev_data));  // R4

  AST_NO_WE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && !ptr_q[1]) |=> $stable(regs_o));  // R5

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && wr_i) |=> $stable(regs_o));  // R9

  AST_UNIMPL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !impl) |-> (rdata_o == 8'h00));  // R6

  AST_UNIMPL_NOWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && !impl) |=> $stable(regs_o));  // R6
endmodule

bind clkreg_port clkreg_port_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_i   (sel_i),
  .wr_i    (wr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .regs_o  (regs_o),
  .ptr_q   (ptr_q)
);

// File: tb/tb_clkreg_port.sv
module tb_clkreg_port;
  localparam int N  = 48;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [N*DW-1:0] regs;

  int total = 0, bad = 0;
  bit done = 0;

  logic [7:0] m_ptr;
  logic [7:0] m_reg [64];

  always #4 clk = ~clk;  // 125 MHz

  clkreg_port #(.NUM_REGS(N), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .regs_o(regs)
  );

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ptr = '0;
      for (int i = 0; i < 64; i++) m_reg[i] = '0;
    end else if (wr && !sel) begin
      m_ptr = {wdata[7:1], 1'b0};
    end else if (wr && sel && m_ptr[1] && int'(m_ptr[7:2]) < N) begin
      m_reg[m_ptr[7:2]] = wdata;
    end
  end

  function automatic logic [7:0] exp_rd(input logic s);
    if (!s) return m_ptr;
    if (int'(m_ptr[7:2]) < N) return m_reg[m_ptr[7:2]];
    return 8'h00;
  endfunction

  function automatic logic [N*DW-1:0] exp_regs();
    logic [N*DW-1:0] v;
    for (int i = 0; i < N; i++) v[i*DW +: DW] = m_reg[i];
    return v;
  endfunction

  task automatic chk8(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic chkv(input logic [N*DW-1:0] act, input logic [N*DW-1:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk8(rdata, exp_rd(sel), sel ? "R6 window read" : "R2 pointer read");
      chkv(regs, exp_regs(), "R9 sideband");
    end
  end

  task automatic step(input logic s, input logic w, input logic [7:0] d);
    @(negedge clk);
    sel = s; wr = w; wdata = d;
  endtask

  task automatic look(input logic s, input logic [7:0] exp, input string tag);
    step(s, 1'b0, 8'h00);
    @(posedge clk); #2;
    chk8(rdata, exp, tag);
  endtask

  function automatic logic [7:0] slice(input int i);
    return regs[i*DW +: DW];
  endfunction

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk8(rdata, 8'h00, "R1 pointer after reset");
    chkv(regs, '0, "R1 bank after reset");
    look(1'b1, 8'h00, "R1 window after reset");

    // R2/R3: bit0 dropped, index 3 with write enable
    step(1'b0, 1'b1, 8'h0F);
    look(1'b0, 8'h0E, "R2 pointer readback");
    step(1'b1, 1'b1, 8'h5A);
    look(1'b1, 8'h5A, "R3 index 3 window");
    chk8(slice(3), 8'h5A, "R3 index 3 sideband");

    // R5: write enable clear, index 4
    step(1'b0, 1'b1, 8'h10);
    step(1'b1, 1'b1, 8'h77);
    look(1'b1, 8'h00, "R5 ignored write");
    chk8(slice(4), 8'h00, "R5 sideband unchanged");

    // R7: three-step write then closed pointer
    step(1'b0, 1'b1, 8'h16);
    step(1'b1, 1'b1, 8'hA5);
    step(1'b0, 1'b1, 8'h14);
    step(1'b1, 1'b1, 8'h3C);
    look(1'b1, 8'hA5, "R7 closed write");

    // R8: same-cycle write and read
    step(1'b0, 1'b1, 8'h0E);
    step(1'b1, 1'b1, 8'hC3);
    #1 chk8(rdata, 8'h5A, "R8 old value in write cycle");
    @(posedge clk); #2;
    chk8(rdata, 8'hC3, "R8 new value after edge");
    chk8(slice(3), 8'hC3, "R4 commit index 3");

    // R6: unimplemented index 50 and top implemented index 47
    step(1'b0, 1'b1, 8'hCA);
    step(1'b1, 1'b1, 8'hFF);
    look(1'b1, 8'h00, "R6 unimplemented reads zero");
    step(1'b0, 1'b1, 8'hBE);
    step(1'b1, 1'b1, 8'h81);
    look(1'b1, 8'h81, "R4 index 47 write");

    // random mix checked by the per-cycle monitor
    for (int k = 0; k < 400; k++) begin
      logic [7:0] d;
      d = 8'($urandom);
      if ($urandom % 3 == 0) step(1'b0, 1'b1, d);
      else step(1'($urandom), 1'($urandom), 8'($urandom));
    end
    step(1'b0, 1'b0, 8'h00);
    @(posedge clk); #3;
    finish_run();
  end
endmodule